// File: doc/BRIEF.md
# Shared System Bus Priority Arbiter

This block decides which of four bus masters owns an on-chip shared system bus. The four masters are a test-interface controller, a DMA engine, an external bus master and the CPU. Each master drives a request line. The arbiter returns a one-hot grant vector, and it is always registered. A single configuration bit picks one of two fixed priority orders. The two orders differ only in the relative rank of the DMA engine and the external master. The test-interface controller always ranks first and the CPU always ranks last.

The CPU is the default master. It holds the bus in these cases:
- while reset is applied;
- while the standby/power-down input is high;
- whenever no other master requests the bus at a decision point.

Ownership moves only at the clock edge on which the transfer-done strobe marks the end of the current bus cycle, so a transfer in flight is never cut off. A lock input from the current owner keeps its grant across transfer boundaries. The system drives the request, lock and power inputs, and bus-side logic uses the grant vector to steer address and control.

Top module: `sysbus_arbiter`

## Requirements
- R1: `gnt_o` is one-hot in every cycle. Bit positions are 0 for the test-interface controller, 1 for DMA, 2 for the external master and 3 for the CPU. The same positions are used in `req_i`.
- R2: Reset is synchronous and active-low. A rising clock edge with `rst_n` low sets `gnt_o` to 4'b1000 (CPU), whatever the other inputs are.
- R3: A decision is taken only at a rising edge where `xfer_done_i` is 1, `lock_i` is 0 and `sleep_i` is 0. At any other edge without sleep or reset, `gnt_o` keeps its value. A new grant appears on `gnt_o` after the deciding edge.
- R4: At a decision, a request on bit 0 (test-interface) wins under either value of `prio_swap_i`.
- R5: With `prio_swap_i` = 0 and no bit-0 request, DMA (bit 1) beats the external master (bit 2).
- R6: With `prio_swap_i` = 1 and no bit-0 request, the external master (bit 2) beats DMA (bit 1).
- R7: If none of bits 0 to 2 request at a decision, the grant goes to the CPU (bit 3). `req_i[3]` has no effect on the outcome.
- R8: While `lock_i` is 1 and `sleep_i` is 0, `gnt_o` holds at transfer-done edges, even against higher-priority requests.
- R9: At any edge with `sleep_i` = 1, the grant moves to the CPU, regardless of transfer-done, lock or requests.
- R10: `prio_swap_i` is looked at only at a decision edge. Toggling it at other edges leaves `gnt_o` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 4 | Bus requests: [0] test-interface, [1] DMA, [2] external, [3] CPU |
| prio_swap_i | input | 1 | 0: DMA above external; 1: external above DMA |
| xfer_done_i | input | 1 | End-of-bus-cycle strobe that opens a decision |
| lock_i | input | 1 | Current owner keeps the bus while high |
| sleep_i | input | 1 | Standby/power-down: park the bus on the CPU |
| gnt_o | output | 4 | Registered one-hot grant, same bit positions as `req_i` |

## Verification
The bench builds the arbiter with its default four-master configuration, because the master set and both priority orders are fixed by the requirements.

At that size, every request pattern can be swept under both priority settings:
- all sixteen request patterns are tried under each value of the swap bit;
- both orderings between DMA and the external master are covered;
- the test-interface override is covered under both settings;
- CPU parking is covered with and without a CPU request.

Targeted sequences cover the following cases:
- holding the grant across edges without a transfer-done strobe;
- a lock that defeats a higher-priority request;
- sleep overriding both lock and the missing strobe;
- a reset applied in the middle of the run.

// File: rtl/arb_pkg.sv
package arb_pkg;

    localparam int unsigned NUM_MST = 4;
    localparam int unsigned MST_W   = $clog2(NUM_MST);

    typedef enum logic [MST_W-1:0] {
        MST_TST = 2'd0,
        MST_DMA = 2'd1,
        MST_EXT = 2'd2,
        MST_CPU = 2'd3
    } mst_e;

    typedef logic [NUM_MST-1:0] mvec_t;

    localparam mst_e DEFAULT_MST = MST_CPU;

    // Master at a given rank (0 = highest) for the chosen ordering.
    function automatic mst_e rank_to_mst(input logic swap, input int unsigned rank);
        mst_e m;
        case (rank)
            0:       m = MST_TST;
            1:       m = swap ? MST_EXT : MST_DMA;
            2:       m = swap ? MST_DMA : MST_EXT;
            default: m = MST_CPU;
        endcase
        return m;
    endfunction

    function automatic mvec_t mst_to_vec(input mst_e m);
        mvec_t v;
        v = '0;
        v[m] = 1'b1;
        return v;
    endfunction

    typedef struct packed {
        mst_e  owner;
        mvec_t gnt;
    } arb_state_t;

endpackage

// File: rtl/arb_prio_resolve.sv
module arb_prio_resolve
    import arb_pkg::*;
(
    input  mvec_t req,
    input  logic  swap,
    output mst_e  winner
);

    // hit[r] is set when the master holding rank r is requesting.
    logic [NUM_MST-1:0] hit;

    for (genvar g = 0; g < NUM_MST; g++) begin : g_rank
        assign hit[g] = req[rank_to_mst(swap, g)];
    end

    always_comb begin
        winner = DEFAULT_MST;
        for (int r = NUM_MST - 1; r >= 0; r--) begin
            if (hit[r]) begin
                winner = rank_to_mst(swap, r);
            end
        end
    end

endmodule

// File: rtl/arb_grant_ctrl.sv
module arb_grant_ctrl
    import arb_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mst_e  winner,
    input  logic  done,
    input  logic  lock,
    input  logic  sleep,
    output mvec_t gnt
);

    arb_state_t st_d, st_q;
    logic       decide;

    always_comb begin
        st_d   = st_q;
        decide = done && !lock && !sleep;
        if (sleep) begin
            st_d.owner = DEFAULT_MST;
        end else if (decide) begin
            st_d.owner = winner;
        end
        st_d.gnt = mst_to_vec(st_d.owner);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.owner <= DEFAULT_MST;
            st_q.gnt   <= mst_to_vec(DEFAULT_MST);
        end else begin
            st_q <= st_d;
        end
    end

    assign gnt = st_q.gnt;

    // R1: exactly one owner at all times after the first edge
    a_r1_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.gnt) == 1);

    // R2: reset parks the bus on the CPU
    a_r2_reset_cpu: assert property (@(posedge clk)
        !rst_n |=> st_q.gnt == mst_to_vec(MST_CPU));

    // R3: no strobe, no sleep -> hold
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !sleep) |=> $stable(st_q.gnt));

    // R8: lock holds the grant
    a_r8_lock_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (lock && !sleep) |=> $stable(st_q.gnt));

    // R9: sleep forces the CPU
    a_r9_sleep_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |=> st_q.gnt == mst_to_vec(MST_CPU));

endmodule

// File: rtl/sysbus_arbiter.sv
module sysbus_arbiter
    import arb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [3:0] req_i,
    input  logic       prio_swap_i,
    input  logic       xfer_done_i,
    input  logic       lock_i,
    input  logic       sleep_i,
    output logic [3:0] gnt_o
);

    mst_e  win;
    mvec_t gnt;

    arb_prio_resolve u_resolve (
        .req    (req_i),
        .swap   (prio_swap_i),
        .winner (win)
    );

    arb_grant_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .winner (win),
        .done   (xfer_done_i),
        .lock   (lock_i),
        .sleep  (sleep_i),
        .gnt    (gnt)
    );

    assign gnt_o = gnt;

    logic open_q;
    assign open_q = xfer_done_i && !lock_i && !sleep_i;

    // R4: test-interface request always wins a decision
    a_r4_tst_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && req_i[0]) |=> gnt_o == 4'b0001);

    // R5: DMA above external with swap low
    a_r5_dma_first: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !req_i[0] && req_i[1] && !prio_swap_i) |=> gnt_o == 4'b0010);

    // R6: external above DMA with swap high
    a_r6_ext_first: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && !req_i[0] && req_i[2] && prio_swap_i) |=> gnt_o == 4'b0100);

    // R7: idle decision parks on the CPU
    a_r7_park_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        (open_q && req_i[2:0] == 3'b000) |=> gnt_o == 4'b1000);

endmodule

// File: tb/sim_sysbus_arbiter.sv
module sim_sysbus_arbiter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] req_i = '0;
    logic       prio_swap_i = 1'b0;
    logic       xfer_done_i = 1'b0;
    logic       lock_i = 1'b0;
    logic       sleep_i = 1'b0;
    logic [3:0] gnt_o;

    always #4 clk = ~clk;

    sysbus_arbiter u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_i       (req_i),
        .prio_swap_i (prio_swap_i),
        .xfer_done_i (xfer_done_i),
        .lock_i      (lock_i),
        .sleep_i     (sleep_i),
        .gnt_o       (gnt_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [3:0] exp_q [$];
    string      tag_q [$];
    logic [3:0] model_gnt = 4'b1000;
    bit         finished = 0;

    function automatic logic [3:0] pick(input logic [3:0] r, input logic s);
        if (r[0])       return 4'b0001;
        if (!s) begin
            if (r[1])   return 4'b0010;
            if (r[2])   return 4'b0100;
        end else begin
            if (r[2])   return 4'b0100;
            if (r[1])   return 4'b0010;
        end
        return 4'b1000;
    endfunction

    task automatic step(input logic rst, input logic [3:0] r, input logic s,
                        input logic dn, input logic lk, input logic sl,
                        input string tag);
        @(negedge clk);
        rst_n = rst; req_i = r; prio_swap_i = s;
        xfer_done_i = dn; lock_i = lk; sleep_i = sl;
        if (!rst)            model_gnt = 4'b1000;
        else if (sl)         model_gnt = 4'b1000;
        else if (dn && !lk)  model_gnt = pick(r, s);
        exp_q.push_back(model_gnt);
        tag_q.push_back(tag);
    endtask

    // Monitor: sample 2 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                logic [3:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_cmp++;
                if (gnt_o !== e) begin
                    n_bad++;
                    $display("FAIL %s: gnt_o=%b expected=%b", t, gnt_o, e);
                end
                n_cmp++;
                if ($countones(gnt_o) != 1) begin
                    n_bad++;
                    $display("FAIL R1: gnt_o=%b expected one-hot", gnt_o);
                end
            end
        end
    end

    initial begin
        #(8 * 20000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        step(0, 4'b0111, 1, 1, 0, 0, "R2");
        step(0, 4'b0000, 0, 0, 0, 0, "R2");
        step(1, 4'b0000, 0, 1, 0, 0, "R7");
        step(1, 4'b1000, 0, 1, 0, 0, "R7");
        step(1, 4'b0110, 0, 1, 0, 0, "R5");
        step(1, 4'b0110, 1, 1, 0, 0, "R6");
        step(1, 4'b0111, 1, 1, 0, 0, "R4");
        step(1, 4'b0111, 0, 1, 0, 0, "R4");
        step(1, 4'b0010, 0, 0, 0, 0, "R3");
        step(1, 4'b0000, 1, 0, 0, 0, "R10");
        step(1, 4'b0100, 0, 1, 0, 0, "R3");
        step(1, 4'b0001, 0, 1, 1, 0, "R8");
        step(1, 4'b0000, 0, 1, 1, 0, "R8");
        step(1, 4'b0001, 0, 1, 1, 1, "R9");
        step(1, 4'b0001, 0, 0, 0, 1, "R9");
        step(1, 4'b0010, 0, 0, 0, 0, "R3");
        step(1, 4'b0010, 0, 1, 0, 0, "R3");
        step(1, 4'b0110, 1, 0, 0, 0, "R10");
        step(1, 4'b0110, 0, 1, 0, 0, "R10");
        step(1, 4'b0110, 1, 1, 0, 0, "R6");
        step(0, 4'b0001, 0, 1, 0, 0, "R2");
        step(1, 4'b0000, 0, 1, 0, 0, "R7");
        for (int s = 0; s < 2; s++) begin
            for (int r = 0; r < 16; r++) begin
                step(1, r[3:0], s[0], 1, 0, 0, "R4_R5_R6_R7");
            end
        end
        step(1, 4'b0000, 0, 0, 0, 0, "R3");
        repeat (3) @(posedge clk);
        #3;
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule